// File: doc/BRIEF.md
# Grouped Instruction Queue with Dependency-Checked Dispatch

This block sits between instruction fetch and the execution pipelines. Fetch hands it groups of up to four instructions, each slot flagged by a valid mask. Each group is written into a four-entry group queue as one unit. Once per cycle the oldest group may move into a single dispatch stage. It moves only when the dispatch stage is known to be empty at the end of that cycle, which means the stage was already empty or everything in it issues in that cycle.

The dispatch stage checks each instruction's enabled source registers against a scoreboard of destinations still in flight. It also checks them against the destinations of older instructions in the same group. Instructions ahead of the first dependent one issue. The dependent one and all younger ones stay in their slot positions until the hazard clears. Issued instructions that write a register mark it busy, and a writeback port clears it. A flush input empties the queue and the dispatch stage but leaves the scoreboard untouched, because older work is still in flight.

Top module: `giq_grouped_queue`

## Requirements
- R1: After reset the queue and dispatch stage are empty, `full_o` is 0, `issue_mask_o` is 0 and no register is marked busy.
- R2: A group is accepted at a clock edge when `enq_valid_i` is 1, `enq_mask_i` is nonzero, `full_o` is 0 and `flush_i` is 0. Groups leave in arrival order with their mask unchanged, and a group with an all-zero mask is dropped.
- R3: `full_o` is 1 exactly when four groups are queued. While it is 1, an offered group is discarded and never issues.
- R4: `flush_i` has priority over everything else. In that cycle `issue_mask_o` is 0 and no group is accepted. After the edge the queue and dispatch stage are empty. Busy registers stay busy.
- R5: The head group enters dispatch at an edge only if every valid dispatch slot issues in that cycle or the stage is empty. A group accepted at edge k can issue no earlier than the cycle after edge k+1.
- R6: A valid dispatch slot is dependent when one of its enabled sources (`rs1_en`/`rs2_en` = 1) names a busy register. It is also dependent when that source equals the `rd` of an older valid slot (lower index) in the same group that has `rd_we` = 1.
- R7: Slots below the lowest-indexed dependent slot issue. That slot and all higher slots are held, keeping their slot index and contents, and are re-examined every cycle.
- R8: An issued slot with `rd_we` = 1 marks `rd` busy from the next cycle. `wb_valid_i` clears `wb_rd_i` from the next cycle. A writeback does not unblock dispatch in its own cycle, and if an issue sets the same register at the same edge, the register stays busy.
- R9: `issue_mask_o[s]` = 1 means slot s issues this cycle. Slot s's tag is on `issue_tag_o[8s+7:8s]`, its destination on `issue_rd_o[5s+4:5s]` and its write enable on `issue_rd_we_o[s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty queue and dispatch stage |
| enq_valid_i | input | 1 | Offer a group |
| enq_mask_i | input | 4 | Per-slot valid of the offered group |
| enq_tag_i | input | 32 | Slot tags, 8 bits each |
| enq_rs1_i | input | 20 | First source per slot, 5 bits each |
| enq_rs1_en_i | input | 4 | First source used |
| enq_rs2_i | input | 20 | Second source per slot |
| enq_rs2_en_i | input | 4 | Second source used |
| enq_rd_i | input | 20 | Destination per slot |
| enq_rd_we_i | input | 4 | Destination written |
| wb_valid_i | input | 1 | Writeback completes |
| wb_rd_i | input | 5 | Register written back |
| full_o | output | 1 | Queue holds four groups |
| issue_mask_o | output | 4 | Slots issuing this cycle |
| issue_tag_o | output | 32 | Tags of dispatch slots |
| issue_rd_o | output | 20 | Destinations of dispatch slots |
| issue_rd_we_o | output | 4 | Destination write enables of dispatch slots |

## Verification
Several events can land in the same cycle. A flush can arrive together with an offered group while a dependent group sits in dispatch and a further group waits in the queue. The bench then requires no issue in that cycle and empty stages afterwards. It also checks that the register busy before the flush still blocks a later reader. A second collision puts a writeback of a register and the issue of a new writer of the same register on the same edge. The bench then requires the consumer that follows to stay held for one more cycle, until a separate writeback arrives.

// File: rtl/giq_pkg.sv
package giq_pkg;
  parameter int unsigned TAG_W    = 8;
  parameter int unsigned REG_W    = 5;
  parameter int unsigned NUM_REGS = 1 << REG_W;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] rs1;
    logic             rs1_en;
    logic [REG_W-1:0] rs2;
    logic             rs2_en;
    logic [REG_W-1:0] rd;
    logic             rd_we;
  } slot_t;
endpackage

// File: rtl/giq_group_fifo.sv
module giq_group_fifo
  import giq_pkg::*;
#(
  parameter int unsigned GROUPS = 4,
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned PTR_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int unsigned CNT_W = $clog2(GROUPS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  push_i,
  input  logic [SLOTS-1:0]      push_mask_i,
  input  slot_t [SLOTS-1:0]     push_slots_i,
  input  logic                  pop_i,
  output logic                  head_valid_o,
  output logic [SLOTS-1:0]      head_mask_o,
  output slot_t [SLOTS-1:0]     head_slots_o,
  output logic                  full_o,
  output logic [CNT_W-1:0]      count_o
);
  slot_t [SLOTS-1:0] mem_q  [GROUPS];
  logic  [SLOTS-1:0] mask_q [GROUPS];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(GROUPS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o       = (cnt_q == CNT_W'(GROUPS));
  assign head_valid_o = (cnt_q != '0);
  assign head_mask_o  = mask_q[rd_ptr_q];
  assign head_slots_o = mem_q[rd_ptr_q];
  assign count_o      = cnt_q;
  assign push_ok      = push_i && !full_o && !flush_i;
  assign pop_ok       = pop_i && head_valid_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  // payload storage carries no reset; validity lives in cnt_q
  always_ff @(posedge clk_i) begin
    if (push_ok) begin
      mem_q[wr_ptr_q]  <= push_slots_i;
      mask_q[wr_ptr_q] <= push_mask_i;
    end
  end
endmodule

// File: rtl/giq_dep_check.sv
module giq_dep_check
  import giq_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic [SLOTS-1:0]    valid_i,
  input  slot_t [SLOTS-1:0]   slots_i,
  input  logic [NUM_REGS-1:0] busy_i,
  output logic [SLOTS-1:0]    blocked_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic hit;
    always_comb begin
      hit = (slots_i[i].rs1_en && busy_i[slots_i[i].rs1]) ||
            (slots_i[i].rs2_en && busy_i[slots_i[i].rs2]);
      // older slot of the same group writing one of our sources
      for (int j = 0; j < i; j++) begin
        if (valid_i[j] && slots_i[j].rd_we &&
            ((slots_i[i].rs1_en && slots_i[j].rd == slots_i[i].rs1) ||
             (slots_i[i].rs2_en && slots_i[j].rd == slots_i[i].rs2)))
          hit = 1'b1;
      end
    end
    assign blocked_o[i] = valid_i[i] && hit;
  end
endmodule

// File: rtl/giq_scoreboard.sv
module giq_scoreboard
  import giq_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SLOTS-1:0]    issue_mask_i,
  input  slot_t [SLOTS-1:0]   issue_slots_i,
  input  logic                wb_valid_i,
  input  logic [REG_W-1:0]    wb_rd_i,
  output logic [NUM_REGS-1:0] busy_o
);
  logic [NUM_REGS-1:0] busy_q, set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (issue_mask_i[s] && issue_slots_i[s].rd_we)
        set_vec[issue_slots_i[s].rd] = 1'b1;
    end
    clr_vec = wb_valid_i ? (NUM_REGS'(1) << wb_rd_i) : '0;
  end

  // set after clear: a fresh writer wins over a stale writeback
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q & ~clr_vec) | set_vec;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/giq_dispatch_stage.sv
module giq_dispatch_stage
  import giq_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                head_valid_i,
  input  logic [SLOTS-1:0]    head_mask_i,
  input  slot_t [SLOTS-1:0]   head_slots_i,
  input  logic [NUM_REGS-1:0] busy_i,
  output logic                pop_o,
  output logic [SLOTS-1:0]    issue_mask_o,
  output slot_t [SLOTS-1:0]   slots_o,
  output logic [SLOTS-1:0]    valid_o
);
  logic [SLOTS-1:0] valid_q, blocked, hold, release_v;
  slot_t [SLOTS-1:0] slots_q;
  logic drains;

  giq_dep_check #(.SLOTS(SLOTS)) u_dep (
    .valid_i  (valid_q),
    .slots_i  (slots_q),
    .busy_i   (busy_i),
    .blocked_o(blocked)
  );

  always_comb begin
    hold[0] = blocked[0];
    for (int i = 1; i < SLOTS; i++) hold[i] = hold[i-1] | blocked[i];
  end

  assign release_v = valid_q & ~hold & {SLOTS{!flush_i}};
  assign drains    = ((valid_q & ~release_v) == '0);
  assign pop_o     = drains && head_valid_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (pop_o)   valid_q <= head_mask_i;
    else              valid_q <= valid_q & ~release_v;
  end

  always_ff @(posedge clk_i) begin
    if (pop_o) slots_q <= head_slots_i;
  end

  assign issue_mask_o = release_v;
  assign slots_o      = slots_q;
  assign valid_o      = valid_q;
endmodule

// File: rtl/giq_grouped_queue.sv
module giq_grouped_queue
  import giq_pkg::*;
#(
  parameter int unsigned GROUPS = 4,
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned CNT_W = $clog2(GROUPS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   enq_valid_i,
  input  logic [SLOTS-1:0]       enq_mask_i,
  input  logic [SLOTS*TAG_W-1:0] enq_tag_i,
  input  logic [SLOTS*REG_W-1:0] enq_rs1_i,
  input  logic [SLOTS-1:0]       enq_rs1_en_i,
  input  logic [SLOTS*REG_W-1:0] enq_rs2_i,
  input  logic [SLOTS-1:0]       enq_rs2_en_i,
  input  logic [SLOTS*REG_W-1:0] enq_rd_i,
  input  logic [SLOTS-1:0]       enq_rd_we_i,
  input  logic                   wb_valid_i,
  input  logic [REG_W-1:0]       wb_rd_i,
  output logic                   full_o,
  output logic [SLOTS-1:0]       issue_mask_o,
  output logic [SLOTS*TAG_W-1:0] issue_tag_o,
  output logic [SLOTS*REG_W-1:0] issue_rd_o,
  output logic [SLOTS-1:0]       issue_rd_we_o
);
  slot_t [SLOTS-1:0]   enq_slots, head_slots, disp_slots;
  logic  [SLOTS-1:0]   head_mask, disp_valid;
  logic  [NUM_REGS-1:0] busy;
  logic  [CNT_W-1:0]   q_count;
  logic                head_valid, pop;

  for (genvar s = 0; s < SLOTS; s++) begin : g_pack
    assign enq_slots[s] = '{tag:    enq_tag_i[s*TAG_W +: TAG_W],
                            rs1:    enq_rs1_i[s*REG_W +: REG_W],
                            rs1_en: enq_rs1_en_i[s],
                            rs2:    enq_rs2_i[s*REG_W +: REG_W],
                            rs2_en: enq_rs2_en_i[s],
                            rd:     enq_rd_i[s*REG_W +: REG_W],
                            rd_we:  enq_rd_we_i[s]};
    assign issue_tag_o[s*TAG_W +: TAG_W] = disp_slots[s].tag;
    assign issue_rd_o[s*REG_W +: REG_W]  = disp_slots[s].rd;
    assign issue_rd_we_o[s]              = disp_slots[s].rd_we;
  end

  giq_group_fifo #(.GROUPS(GROUPS), .SLOTS(SLOTS)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_i      (enq_valid_i && (enq_mask_i != '0)),
    .push_mask_i (enq_mask_i),
    .push_slots_i(enq_slots),
    .pop_i       (pop),
    .head_valid_o(head_valid),
    .head_mask_o (head_mask),
    .head_slots_o(head_slots),
    .full_o      (full_o),
    .count_o     (q_count)
  );

  giq_dispatch_stage #(.SLOTS(SLOTS)) u_disp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .head_valid_i(head_valid),
    .head_mask_i (head_mask),
    .head_slots_i(head_slots),
    .busy_i      (busy),
    .pop_o       (pop),
    .issue_mask_o(issue_mask_o),
    .slots_o     (disp_slots),
    .valid_o     (disp_valid)
  );

  giq_scoreboard #(.SLOTS(SLOTS)) u_sb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_mask_i (issue_mask_o),
    .issue_slots_i(disp_slots),
    .wb_valid_i   (wb_valid_i),
    .wb_rd_i      (wb_rd_i),
    .busy_o       (busy)
  );
endmodule

// File: rtl/giq_grouped_queue_chk.sv
module giq_grouped_queue_chk #(
  parameter int unsigned GROUPS = 4,
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned CNT_W = $clog2(GROUPS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             full_o,
  input logic [SLOTS-1:0] issue_mask_o,
  input logic [SLOTS-1:0] disp_valid,
  input logic [CNT_W-1:0] q_count
);
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CNT_W'(GROUPS));

  a_r3_full_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !flush_i) |=> (q_count <= $past(q_count)));

  a_r4_flush_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (issue_mask_o == '0));

  a_r4_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (q_count == '0 && disp_valid == '0));

  a_r7_held_stay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && (disp_valid & ~issue_mask_o) != '0)
      |=> (disp_valid == $past(disp_valid & ~issue_mask_o)));

  a_r9_issue_in_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_mask_o & ~disp_valid) == '0);
endmodule

bind giq_grouped_queue giq_grouped_queue_chk #(.GROUPS(GROUPS), .SLOTS(SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .full_o      (full_o),
  .issue_mask_o(issue_mask_o),
  .disp_valid  (disp_valid),
  .q_count     (q_count)
);

// File: tb/giq_grouped_queue_tb_top.sv
module giq_grouped_queue_tb_top;
  import giq_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0, enq_valid_i = 1'b0, wb_valid_i = 1'b0;
  logic [3:0]  enq_mask_i = '0, enq_rs1_en_i = '0, enq_rs2_en_i = '0, enq_rd_we_i = '0;
  logic [31:0] enq_tag_i = '0;
  logic [19:0] enq_rs1_i = '0, enq_rs2_i = '0, enq_rd_i = '0;
  logic [4:0]  wb_rd_i = '0;
  logic        full_o;
  logic [3:0]  issue_mask_o, issue_rd_we_o;
  logic [31:0] issue_tag_o;
  logic [19:0] issue_rd_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  giq_grouped_queue dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .enq_valid_i(enq_valid_i), .enq_mask_i(enq_mask_i), .enq_tag_i(enq_tag_i),
    .enq_rs1_i(enq_rs1_i), .enq_rs1_en_i(enq_rs1_en_i),
    .enq_rs2_i(enq_rs2_i), .enq_rs2_en_i(enq_rs2_en_i),
    .enq_rd_i(enq_rd_i), .enq_rd_we_i(enq_rd_we_i),
    .wb_valid_i(wb_valid_i), .wb_rd_i(wb_rd_i),
    .full_o(full_o), .issue_mask_o(issue_mask_o), .issue_tag_o(issue_tag_o),
    .issue_rd_o(issue_rd_o), .issue_rd_we_o(issue_rd_we_o)
  );

  // inputs change just after the falling edge, checks run 1 unit later
  task automatic cyc();
    @(negedge clk);
    enq_valid_i = 1'b0; flush_i = 1'b0; wb_valid_i = 1'b0;
  endtask
  task automatic settle(); #1; endtask

  task automatic clr_slots();
    enq_tag_i = '0; enq_rs1_i = '0; enq_rs2_i = '0; enq_rd_i = '0;
    enq_rs1_en_i = '0; enq_rs2_en_i = '0; enq_rd_we_i = '0;
  endtask

  task automatic put(input int s, input logic [7:0] tag,
                     input logic [4:0] rs1, input logic rs1_en,
                     input logic [4:0] rd, input logic rd_we);
    enq_tag_i[s*8 +: 8]  = tag;
    enq_rs1_i[s*5 +: 5]  = rs1;
    enq_rs1_en_i[s]      = rs1_en;
    enq_rd_i[s*5 +: 5]   = rd;
    enq_rd_we_i[s]       = rd_we;
  endtask

  task automatic plain_group(input logic [7:0] base);
    clr_slots();
    for (int s = 0; s < 4; s++) put(s, base + 8'(s), 5'd0, 1'b0, 5'd0, 1'b0);
  endtask

  task automatic offer(input logic [3:0] mask);
    enq_valid_i = 1'b1; enq_mask_i = mask;
  endtask

  task automatic chk_mask(input string req, input logic [3:0] exp);
    checks++;
    if (issue_mask_o !== exp) begin
      errors++;
      $display("FAIL %s issue_mask act=%b exp=%b", req, issue_mask_o, exp);
    end
  endtask

  task automatic chk_tag(input string req, input int s, input logic [7:0] exp);
    checks++;
    if (issue_tag_o[s*8 +: 8] !== exp) begin
      errors++;
      $display("FAIL %s slot%0d tag act=%h exp=%h", req, s, issue_tag_o[s*8 +: 8], exp);
    end
  endtask

  task automatic chk_full(input string req, input logic exp);
    checks++;
    if (full_o !== exp) begin
      errors++;
      $display("FAIL %s full act=%b exp=%b", req, full_o, exp);
    end
  endtask

  task automatic chk_rd(input string req, input int s, input logic [4:0] rd, input logic we);
    checks++;
    if (issue_rd_o[s*5 +: 5] !== rd || issue_rd_we_o[s] !== we) begin
      errors++;
      $display("FAIL %s slot%0d rd/we act=%0d/%b exp=%0d/%b", req, s,
               issue_rd_o[s*5 +: 5], issue_rd_we_o[s], rd, we);
    end
  endtask

  task automatic t_reset();
    #1;
    chk_full("R1", 1'b0);
    chk_mask("R1", 4'b0000);
    cyc(); cyc(); rst_ni = 1'b1;
  endtask

  // every source enabled on a different register: none is busy after reset
  task automatic t_basic();
    cyc(); clr_slots();
    for (int s = 0; s < 4; s++) put(s, 8'h01 + 8'(s), 5'(s + 1), 1'b1, 5'd0, 1'b0);
    offer(4'b1111); settle();
    chk_mask("R1", 4'b0000);
    cyc(); settle(); chk_mask("R5 latency", 4'b0000);
    cyc(); settle(); chk_mask("R1 R5 issue", 4'b1111);
    chk_tag("R9", 0, 8'h01); chk_tag("R9", 3, 8'h04);
    cyc(); settle(); chk_mask("R5 drained", 4'b0000);
  endtask

  task automatic t_order();
    cyc(); plain_group(8'h10); offer(4'b0101);
    cyc(); plain_group(8'h20); offer(4'b1000);
    cyc(); plain_group(8'h30); offer(4'b0000); settle();
    chk_mask("R2 first group", 4'b0101);
    chk_tag("R2", 0, 8'h10); chk_tag("R2", 2, 8'h12);
    cyc(); settle(); chk_mask("R2 second group", 4'b1000); chk_tag("R2", 3, 8'h23);
    cyc(); settle(); chk_mask("R2 zero mask dropped", 4'b0000);
    cyc(); settle(); chk_mask("R2 zero mask dropped", 4'b0000);
  endtask

  task automatic t_dep();
    cyc(); clr_slots();
    put(0, 8'h40, 5'd0, 1'b0, 5'd5, 1'b1);
    put(1, 8'h41, 5'd5, 1'b1, 5'd0, 1'b0);
    put(2, 8'h42, 5'd0, 1'b0, 5'd0, 1'b0);
    put(3, 8'h43, 5'd0, 1'b0, 5'd0, 1'b0);
    offer(4'b1111);
    cyc(); plain_group(8'h50); offer(4'b1111);
    cyc(); settle();
    chk_mask("R6 intra-group hazard", 4'b0001);
    chk_rd("R9", 0, 5'd5, 1'b1);
    cyc(); wb_valid_i = 1'b1; wb_rd_i = 5'd5; settle();
    chk_mask("R8 writeback same cycle", 4'b0000);
    cyc(); settle();
    chk_mask("R7 remainder", 4'b1110);
    chk_tag("R7", 1, 8'h41); chk_tag("R7", 2, 8'h42); chk_tag("R7", 3, 8'h43);
    cyc(); settle();
    chk_mask("R5 waits for drain", 4'b1111); chk_tag("R5", 0, 8'h50);
    cyc();
  endtask

  task automatic t_full();
    cyc(); clr_slots(); put(0, 8'h60, 5'd0, 1'b0, 5'd7, 1'b1); offer(4'b0001);
    cyc(); clr_slots(); put(0, 8'h61, 5'd7, 1'b1, 5'd0, 1'b0); offer(4'b0001);
    cyc(); settle(); chk_mask("R8 writer issues", 4'b0001);
    for (int g = 0; g < 4; g++) begin
      cyc(); plain_group(8'h70 + 8'(g * 16)); offer(4'b1111); settle();
      chk_mask("R6 scoreboard hold", 4'b0000);
    end
    cyc(); settle(); chk_full("R3", 1'b1);
    plain_group(8'hC0); offer(4'b1111); wb_valid_i = 1'b1; wb_rd_i = 5'd7;
    cyc(); settle(); chk_full("R3", 1'b1);
    chk_mask("R8 cleared", 4'b0001); chk_tag("R8", 0, 8'h61);
    for (int g = 0; g < 4; g++) begin
      cyc(); settle();
      if (g == 0) chk_full("R3 drained", 1'b0);
      chk_mask("R3 R2 order", 4'b1111); chk_tag("R2", 0, 8'h70 + 8'(g * 16));
    end
    cyc(); settle(); chk_mask("R3 extra group dropped", 4'b0000);
  endtask

  task automatic t_flush();
    cyc(); clr_slots(); put(0, 8'hB0, 5'd0, 1'b0, 5'd9, 1'b1); offer(4'b0001);
    cyc(); clr_slots(); put(0, 8'hB1, 5'd9, 1'b1, 5'd0, 1'b0); offer(4'b0001);
    cyc(); plain_group(8'hD0); offer(4'b1111); settle();
    chk_mask("R4 setup", 4'b0001);
    cyc(); flush_i = 1'b1; plain_group(8'hE0); offer(4'b1111); settle();
    chk_mask("R4 flush cycle", 4'b0000);
    cyc(); settle(); chk_mask("R4 emptied", 4'b0000); chk_full("R4", 1'b0);
    cyc(); clr_slots(); put(0, 8'hF0, 5'd9, 1'b1, 5'd0, 1'b0); offer(4'b0001); settle();
    chk_mask("R4 flushed groups gone", 4'b0000);
    cyc(); settle(); chk_mask("R4 flushed groups gone", 4'b0000);
    cyc(); settle(); chk_mask("R4 scoreboard kept", 4'b0000);
    wb_valid_i = 1'b1; wb_rd_i = 5'd9;
    cyc(); settle(); chk_mask("R4 after writeback", 4'b0001); chk_tag("R4", 0, 8'hF0);
  endtask

  task automatic t_setwins();
    cyc(); clr_slots(); put(0, 8'hA0, 5'd0, 1'b0, 5'd3, 1'b1); offer(4'b0001);
    cyc(); clr_slots(); put(0, 8'hA1, 5'd3, 1'b1, 5'd0, 1'b0); offer(4'b0001);
    cyc(); wb_valid_i = 1'b1; wb_rd_i = 5'd3; settle();
    chk_mask("R8 writer issues", 4'b0001);
    cyc(); settle(); chk_mask("R8 set wins", 4'b0000);
    wb_valid_i = 1'b1; wb_rd_i = 5'd3;
    cyc(); settle(); chk_mask("R8 released", 4'b0001); chk_tag("R8", 0, 8'hA1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_order();
    t_dep();
    t_full();
    t_flush();
    t_setwins();
    cyc(); cyc();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule